// File: doc/BRIEF.md
# Clock Source Switch Controller

This block moves the system clock from one oscillator to another at software's request, and sets a post-divider on the chosen clock. Software opens a write window with a two-word key. It then writes the code of the wanted source together with a start bit into the oscillator control register. The controller waits for the chosen source's synchronized ready input to stay high for a fixed number of cycles. If that happens, it drives the new code onto the mux select output and updates the read-only current-source field. If the source is missing or drops out, the request is dropped and the current source stays as it was. In both cases the start bit clears by itself, so software reads it back to learn when the request was handled. It compares the current-source field with the code it asked for to tell a completed switch from a rejected one.

A second protected register holds a 4-bit post-divider code, where the divide ratio is code+1. It also holds two slew enables and a step-interval field. Without slewing, a new code takes effect one cycle after the write. With slewing enabled for the direction of the change, the applied code moves by one every step+1 cycles until it reaches the target. A busy flag stays set for as long as the applied code differs from the target.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset the current source, the select output, the requested source, the start bit, the applied and target divider codes, the slew settings and the busy flag are all zero, and the protected registers are locked.
- R2: The protected registers unlock only when the key register (address 2) receives KEY_A (0xA5A50F0F) and the very next bus write is KEY_B (0x5A5AF0F0) to the key register; any other write in between breaks the sequence.
- R3: After the second key word at clock edge E, one protected write at edges E+1 to E+16 is accepted; later writes are ignored, and the first protected write (accepted or not) closes the window.
- R4: A write to address 0 (oscillator control) or address 1 (divider control) while locked changes nothing.
- R5: An accepted write at edge E to address 0 with bit 0 set and a valid requested source in bits 10:8 whose ready input stays high commits at edge E+4: the current source (bits 14:12, read-only) and the select output take the new code, and bit 0 clears.
- R6: If the requested code is NUM_SRC or higher, or its ready input is low at any edge E+1 to E+4, bit 0 clears at that edge and the current source and select output keep their old value.
- R7: While bit 0 of address 0 is set, writes to address 0 have no effect on the requested-source field or the ongoing switch.
- R8: Address 0 reads back bit 0 start, bits 10:8 requested source, bits 14:12 current source, and zero elsewhere.
- R9: Address 1 holds the target divider code in bits 23:20, the step interval in bits 15:8, the down-scaling slew enable in bit 1, the up-scaling slew enable in bit 2, and reads the busy flag in bit 0.
- R10: When slewing is off for the direction of a change, the applied divider code equals the target one edge after the write, and busy is high for that one cycle only; a write of the code already applied leaves busy low.
- R11: When slewing is on for the direction (bit 1 when the code increases, bit 2 when it decreases), the applied code moves by one each step+1 cycles, so it reaches a target d codes away after d*(step+1) cycles, and busy stays high until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| src_ready_i | input | NUM_SRC | Synchronized ready flags, one per oscillator |
| clk_sel_o | output | 3 | Select for the external clock mux |
| div_code_o | output | 4 | Applied post-divider code (ratio code+1) |

## Verification
The bench walks every requested code from 0 to 7, including the codes with no oscillator behind them. It checks the start bit and the select output on each cycle. A controller that commits one cycle early or late, or that commits an absent source, shows up there. It drops a ready input partway through the stability window, which would catch a design that samples ready only once. It also writes a different source during a pending switch, which would catch a design that retargets in mid-switch. The unlock window is probed at its last valid cycle and one cycle past it, and again right after one protected write has used it. Post-divider codes are swept in both directions with several step intervals and with each slew enable alone, so a wrong direction mapping or an off-by-one step count changes the cycle-by-cycle code the bench expects.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam logic [1:0] ADDR_OSC = 2'd0;
  localparam logic [1:0] ADDR_DIV = 2'd1;
  localparam logic [1:0] ADDR_KEY = 2'd2;
  localparam int SRC_W    = 3;
  localparam int DIV_W    = 4;
  localparam int STEP_W   = 8;
  localparam int NEW_LSB  = 8;
  localparam int CUR_LSB  = 12;
  localparam int STEP_LSB = 8;
  localparam int CODE_LSB = 20;
endpackage

// File: rtl/clksw_unlock.sv
module clksw_unlock
  import clksw_pkg::*;
#(
  parameter logic [31:0] KEY_A = 32'hA5A5_0F0F,
  parameter logic [31:0] KEY_B = 32'h5A5A_F0F0,
  parameter int          WIN   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        open_o
);
  localparam int TW = $clog2(WIN + 1);

  logic          first_q;
  logic [TW-1:0] tmr_q;
  logic          key_wr, prot_wr, key_b_hit;

  assign key_wr    = we_i && (addr_i == ADDR_KEY);
  assign prot_wr   = we_i && (addr_i == ADDR_OSC || addr_i == ADDR_DIV);
  assign key_b_hit = key_wr && first_q && (wdata_i == KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      if (we_i) first_q <= key_wr && (wdata_i == KEY_A);
      if (key_b_hit)          tmr_q <= TW'(WIN);
      else if (prot_wr)       tmr_q <= '0;
      else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
    end
  end

  assign open_o = (tmr_q != '0);

  assert_window_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_wr |=> !open_o);
  assert_open_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q > $past(tmr_q)) |-> $past(first_q && key_wr));
endmodule

// File: rtl/clksw_switch.sv
module clksw_switch
  import clksw_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int STABLE  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [SRC_W-1:0]   new_i,
  input  logic               swen_i,
  input  logic [NUM_SRC-1:0] src_ready_i,
  output logic [SRC_W-1:0]   cur_o,
  output logic [SRC_W-1:0]   new_o,
  output logic               swen_o
);
  localparam int NCODE = 1 << SRC_W;
  localparam int CW    = $clog2(STABLE + 1);

  logic [NCODE-1:0] rdy_pad;
  logic [SRC_W-1:0] cur_q, new_q;
  logic             swen_q, rdy_ok;
  logic [CW-1:0]    cnt_q;

  for (genvar i = 0; i < NCODE; i++) begin : g_pad
    if (i < NUM_SRC) begin : g_src
      assign rdy_pad[i] = src_ready_i[i];
    end else begin : g_none
      assign rdy_pad[i] = 1'b0;
    end
  end

  assign rdy_ok = rdy_pad[new_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      new_q  <= '0;
      swen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (swen_q) begin
      if (!rdy_ok) begin
        swen_q <= 1'b0;
        cnt_q  <= '0;
      end else if (cnt_q == CW'(STABLE - 1)) begin
        cur_q  <= new_q;
        swen_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (wr_i) begin
      new_q  <= new_i;
      swen_q <= swen_i;
    end
  end

  assign cur_o  = cur_q;
  assign new_o  = new_q;
  assign swen_o = swen_q;

  assert_commit_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> ($past(swen_q) && cur_q == $past(new_q) && !swen_q));
  assert_commit_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_q) |-> $past(rdy_ok));
  assert_new_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swen_q |=> $stable(new_q));
endmodule

// File: rtl/clksw_postdiv.sv
module clksw_postdiv
  import clksw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DIV_W-1:0]  code_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              dn_en_i,
  input  logic              up_en_i,
  output logic [DIV_W-1:0]  tgt_o,
  output logic [DIV_W-1:0]  app_o,
  output logic [STEP_W-1:0] step_o,
  output logic              dn_en_o,
  output logic              up_en_o,
  output logic              busy_o
);
  logic [DIV_W-1:0]  tgt_q, app_q;
  logic [STEP_W-1:0] step_q, cnt_q;
  logic              dn_q, up_q, rising, slew_en;

  assign rising  = tgt_q > app_q;
  assign slew_en = rising ? dn_q : up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      step_q <= '0;
      dn_q   <= 1'b0;
      up_q   <= 1'b0;
    end else if (wr_i) begin
      tgt_q  <= code_i;
      step_q <= step_i;
      dn_q   <= dn_en_i;
      up_q   <= up_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      app_q <= '0;
      cnt_q <= '0;
    end else if (app_q != tgt_q) begin
      if (!slew_en) begin
        app_q <= tgt_q;
        cnt_q <= '0;
      end else if (cnt_q == step_q) begin
        app_q <= rising ? app_q + 1'b1 : app_q - 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign tgt_o   = tgt_q;
  assign app_o   = app_q;
  assign step_o  = step_q;
  assign dn_en_o = dn_q;
  assign up_en_o = up_q;
  assign busy_o  = (app_q != tgt_q);

  assert_step_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && slew_en) |=> (app_q == $past(app_q) ||
                             app_q == DIV_W'($past(app_q) + 1'b1) ||
                             app_q == DIV_W'($past(app_q) - 1'b1)));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(app_q));
  assert_no_overshoot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rising) |=> app_q <= $past(tgt_q));
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int          NUM_SRC = 6,
  parameter int          STABLE  = 4,
  parameter int          WIN     = 16,
  parameter logic [31:0] KEY_A   = 32'hA5A5_0F0F,
  parameter logic [31:0] KEY_B   = 32'h5A5A_F0F0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_ready_i,
  output logic [2:0]         clk_sel_o,
  output logic [3:0]         div_code_o
);
  logic              open, osc_wr, div_wr;
  logic [SRC_W-1:0]  cur, nsrc;
  logic              swen, busy, dn_en, up_en;
  logic [DIV_W-1:0]  tgt, app;
  logic [STEP_W-1:0] step;
  logic [31:0]       osc_rd, div_rd;

  assign osc_wr = bus_we_i && open && (bus_addr_i == ADDR_OSC);
  assign div_wr = bus_we_i && open && (bus_addr_i == ADDR_DIV);

  clksw_unlock #(.KEY_A(KEY_A), .KEY_B(KEY_B), .WIN(WIN)) u_unlock (
    .clk_i, .rst_ni, .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .open_o(open)
  );

  clksw_switch #(.NUM_SRC(NUM_SRC), .STABLE(STABLE)) u_switch (
    .clk_i, .rst_ni, .wr_i(osc_wr),
    .new_i(bus_wdata_i[NEW_LSB +: SRC_W]), .swen_i(bus_wdata_i[0]),
    .src_ready_i, .cur_o(cur), .new_o(nsrc), .swen_o(swen)
  );

  clksw_postdiv u_postdiv (
    .clk_i, .rst_ni, .wr_i(div_wr),
    .code_i(bus_wdata_i[CODE_LSB +: DIV_W]), .step_i(bus_wdata_i[STEP_LSB +: STEP_W]),
    .dn_en_i(bus_wdata_i[1]), .up_en_i(bus_wdata_i[2]),
    .tgt_o(tgt), .app_o(app), .step_o(step), .dn_en_o(dn_en), .up_en_o(up_en),
    .busy_o(busy)
  );

  always_comb begin
    osc_rd = '0;
    osc_rd[0] = swen;
    osc_rd[NEW_LSB +: SRC_W] = nsrc;
    osc_rd[CUR_LSB +: SRC_W] = cur;
    div_rd = '0;
    div_rd[0] = busy;
    div_rd[1] = dn_en;
    div_rd[2] = up_en;
    div_rd[STEP_LSB +: STEP_W] = step;
    div_rd[CODE_LSB +: DIV_W] = tgt;
    case (bus_addr_i)
      ADDR_OSC: bus_rdata_o = osc_rd;
      ADDR_DIV: bus_rdata_o = div_rd;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign clk_sel_o  = cur;
  assign div_code_o = app;

  assert_locked_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_DIV && !open) |=> $stable(tgt) && $stable(step));
  assert_locked_osc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == ADDR_OSC && !open && !swen) |=> $stable(nsrc) && !swen);
endmodule

// File: tb/clksw_ctrl_tb.sv
`timescale 1ns/1ps
module clksw_ctrl_tb_top;
  localparam logic [31:0] KA = 32'hA5A5_0F0F;
  localparam logic [31:0] KB = 32'h5A5A_F0F0;
  localparam int NSRC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NSRC-1:0] rdy = '1;
  logic [2:0]  sel;
  logic [3:0]  dcode;
  int n_chk = 0, n_fail = 0;
  int cur_exp = 0;
  int code_exp = 0;

  always #5 clk = ~clk;

  clksw_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .src_ready_i(rdy),
    .clk_sel_o(sel), .div_code_o(dcode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic unlock();
    wr(2'd2, KA);
    wr(2'd2, KB);
  endtask

  function automatic logic [31:0] div_word(int code, int step, bit up, bit dn);
    return (32'(code) << 20) | (32'(step) << 8) | (32'(up) << 2) | (32'(dn) << 1);
  endfunction

  // one switch request: check start bit, current field and select each cycle
  task automatic switch_case(input int t, input string tag);
    logic [31:0] v;
    bit valid;
    int prev;
    prev = cur_exp;
    valid = (t < NSRC) && rdy[t];
    unlock();
    wr(2'd0, (32'(t) << 8) | 32'd1);
    for (int k = 0; k < 6; k++) begin
      rd(2'd0, v);
      chk({tag, " start bit"}, int'(v[0]), valid ? int'(k < 4) : int'(k < 1));
      chk({tag, " cur field"}, int'(v[14:12]), (valid && k >= 4) ? t : prev);
      chk({tag, " select"}, int'(sel), (valid && k >= 4) ? t : prev);
      chk("R8 new field", int'(v[10:8]), t);
      @(negedge clk);
    end
    if (valid) cur_exp = t;
  endtask

  // divider move from code_exp to t, checked every cycle
  task automatic div_case(input int t, input int s, input bit up, input bit dn);
    logic [31:0] v;
    int a, d, steps, exp_code;
    bit en;
    a = code_exp;
    d = (t > a) ? t - a : a - t;
    en = (t > a) ? dn : up;
    unlock();
    wr(2'd1, div_word(t, s, up, dn));
    rd(2'd1, v);
    chk("R9 code field", int'(v[23:20]), t);
    chk("R9 step field", int'(v[15:8]), s);
    chk("R9 enable bits", int'(v[2:1]), {up, dn});
    for (int m = 0; m <= d * (s + 1) + 1; m++) begin
      if (en) begin
        steps = m / (s + 1);
        if (steps > d) steps = d;
        exp_code = (t > a) ? a + steps : a - steps;
        rd(2'd1, v);
        chk("R11 applied code", int'(dcode), exp_code);
        chk("R11 busy", int'(v[0]), int'(steps < d));
      end else begin
        rd(2'd1, v);
        chk("R10 applied code", int'(dcode), (m == 0) ? a : t);
        chk("R10 busy", int'(v[0]), int'(m == 0 && d != 0));
      end
      @(negedge clk);
    end
    code_exp = t;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 osc reg", int'(v), 0);
    rd(2'd1, v); chk("R1 div reg", int'(v), 0);
    chk("R1 select", int'(sel), 0);
    chk("R1 div code", int'(dcode), 0);

    // R4 locked writes
    wr(2'd0, (32'd3 << 8) | 32'd1);
    rd(2'd0, v); chk("R4 osc locked", int'(v), 0);
    wr(2'd1, div_word(7, 3, 1, 1));
    @(negedge clk);
    rd(2'd1, v); chk("R4 div locked", int'(v), 0);
    chk("R4 div code", int'(dcode), 0);

    // R2 broken sequences
    wr(2'd2, KA); wr(2'd1, div_word(7, 0, 0, 0)); wr(2'd2, KB);
    wr(2'd1, div_word(7, 0, 0, 0));
    rd(2'd1, v); chk("R2 interleaved write", int'(v[23:20]), 0);
    wr(2'd2, KA); wr(2'd2, 32'h1); wr(2'd2, KB);
    wr(2'd1, div_word(7, 0, 0, 0));
    rd(2'd1, v); chk("R2 wrong key word", int'(v[23:20]), 0);
    wr(2'd2, KB); wr(2'd2, KA);
    wr(2'd1, div_word(0, 9, 0, 0));
    rd(2'd1, v); chk("R2 reversed keys", int'(v[15:8]), 0);
    unlock();
    wr(2'd1, div_word(0, 9, 0, 0));
    rd(2'd1, v); chk("R2 proper keys", int'(v[15:8]), 9);

    // R3 window edge and consumption
    unlock(); repeat (15) @(negedge clk);
    wr(2'd1, div_word(0, 8'h15, 0, 0));
    rd(2'd1, v); chk("R3 last cycle of window", int'(v[15:8]), 8'h15);
    unlock(); repeat (16) @(negedge clk);
    wr(2'd1, div_word(0, 8'h2A, 0, 0));
    rd(2'd1, v); chk("R3 window expired", int'(v[15:8]), 8'h15);
    unlock();
    wr(2'd1, div_word(0, 8'h33, 0, 0));
    wr(2'd1, div_word(0, 8'h44, 0, 0));
    rd(2'd1, v); chk("R3 window consumed", int'(v[15:8]), 8'h33);

    // R5/R6 sweep of all requested codes, all sources ready
    for (int i = 0; i < 8; i++) switch_case((i + 1) % 8, "R5 R6 sweep");

    // R6 target not ready at start
    rdy = 6'b111011;
    switch_case(2, "R6 not ready");
    chk("R6 select kept", int'(sel), 0);
    rdy = '1;

    // R6 ready drops inside the stability window
    begin
      int prev;
      prev = cur_exp;
      unlock();
      wr(2'd0, (32'd4 << 8) | 32'd1);
      for (int k = 0; k < 5; k++) begin
        rd(2'd0, v);
        chk("R6 drop start bit", int'(v[0]), int'(k < 2));
        chk("R6 drop cur field", int'(v[14:12]), prev);
        if (k == 1) rdy[4] = 1'b0;
        @(negedge clk);
      end
      rdy = '1;
    end

    // R7 write during a pending switch
    unlock();
    wr(2'd0, (32'd3 << 8) | 32'd1);
    unlock();
    wr(2'd0, (32'd5 << 8) | 32'd1);
    rd(2'd0, v);
    chk("R7 start bit", int'(v[0]), 1);
    chk("R7 new field held", int'(v[10:8]), 3);
    @(negedge clk);
    rd(2'd0, v);
    chk("R7 committed original", int'(v[14:12]), 3);
    chk("R7 start cleared", int'(v[0]), 0);
    chk("R7 select", int'(sel), 3);
    cur_exp = 3;
    @(negedge clk);
    rd(2'd0, v);
    chk("R7 no second switch", int'(v[0]), 0);

    // R10 immediate divider changes, full code sweep
    for (int i = 0; i < 16; i++) div_case((i + 1) % 16, 0, 0, 0);
    div_case(0, 0, 0, 0);

    // R11 slewed changes
    div_case(5, 0, 1, 1);
    div_case(1, 2, 1, 1);
    div_case(9, 3, 1, 1);
    div_case(12, 1, 0, 1);
    div_case(4, 1, 0, 1);
    div_case(7, 2, 1, 0);
    div_case(2, 2, 1, 0);
    div_case(15, 0, 1, 1);
    div_case(0, 1, 1, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule